// File: doc/BRIEF.md
# Packet Header Byte Relocation Formatter

The formatter takes in a fixed-size cell of sixteen 32-bit words over a valid/ready stream. Byte 0 of every word is bits 31:24 and byte 3 is bits 7:0. The first five words go into a small header store. Words five to fifteen go into a separate payload store. Once the fifth word has been accepted, a move engine rearranges the header store with five in-place byte swaps, one per cycle. These swaps run while the remaining words are still coming in. The swaps gather the routing header, meaning the qualifier byte and up to four bitmap bytes, into the leading byte positions of the cell. A configuration word of five 3-bit position indices sets where each swap reads from. Each swap sees the result of the swaps before it.

After the sixteenth word, the cell goes out as four 128-bit logical units. Unit 0 is the master unit and carries the relocated qualifier and bitmap bytes in its first slots. Units 1 to 3 are slaves and carry payload. The block checks even parity over the first three or the first five relocated header bytes. Three bytes suit the small-port modes, where only the first two bitmap bytes name destinations and the other two count as payload. The result is reported with the master unit.

Back-pressure rules: `in_ready` is high while a cell is being filled and low from the cycle after the sixteenth word is accepted until the last unit has been handed over. A unit stays on `out_data` with `out_valid` high until `out_ready` takes it. Only one cell is held at a time.

Top module: `hrf_formatter`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A word is taken only on a clock edge with `in_valid` and `in_ready` both high, and a cell is exactly 16 taken words. `in_ready` is 0 from the edge that takes word 15 until the edge that hands over unit 3. It is 1 again on the following cycle.
- R3: A held cell leaves as four beats with `out_lu` = 0, 1, 2, 3 in that order. `out_sop` is 1 on beat 0 only. Within unit j, slot Cn (n = 0..15) is `out_data[127-8n -: 8]` and holds cell byte 16j+n. Cell byte p is byte p%4 of word p/4, after relocation.
- R4: Relocation applies moves k = 0..4 in order. Move k reads index `cfg_pos[3k+2:3k]` (a value 0..7) and swaps cell byte k with the cell byte at that index. Each move acts on the bytes left by the moves before it.
- R5: A move whose index equals k leaves the cell unchanged. With the indices set to 0,1,2,3,4, every byte leaves in its arrival position.
- R6: `out_par_err` is 1 on beat 0 when the XOR of all bits of relocated bytes 0..2 (`cfg_par5` = 0) or bytes 0..4 (`cfg_par5` = 1) is 1. In every other case it is 0, and it is 0 on beats 1 to 3.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_lu`, `out_data` and `out_par_err` hold their values.
- R8: `cfg_pos` and `cfg_par5` are sampled on the edge that takes word 4 of a cell. Changing them afterwards does not affect that cell.
- R9: Cell bytes 8 to 63 are never moved, so words 2 to 15 leave exactly as they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_pos | input | 15 | Five 3-bit move indices, move k in bits 3k+2:3k |
| cfg_par5 | input | 1 | Parity span: 0 = three header bytes, 1 = five |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Formatter can take a word |
| in_data | input | 32 | Input word, byte 0 in bits 31:24 |
| out_valid | output | 1 | Logical unit present |
| out_ready | input | 1 | Sink takes the unit |
| out_data | output | 128 | Logical unit, slot C00 in bits 127:120 |
| out_sop | output | 1 | Beat is the master unit of a cell |
| out_lu | output | 2 | Index of the unit on the bus |
| out_par_err | output | 1 | Header parity failed, valid on the master beat |

## Verification
The swap sequence and the capture of payload words share cycles. When words arrive with no gaps, the five moves run on the five edges after word 4 while words 5 to 9 are being written. The bench drives cells both gap-free and with idle cycles, using chained indices in which later moves fetch bytes placed by earlier moves. It also changes the configuration inputs in the middle of the move sequence. Each unit is compared against a byte model built from the requirements, and the comparison must show only the configuration sampled at word 4.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int WORD_B    = WORD_W / BYTE_W;
  localparam int CELL_WDS  = 16;
  localparam int HDR_WDS   = 5;
  localparam int MOVES     = 5;
  localparam int IDX_W     = 3;
  localparam int LU_WDS    = 4;
  localparam int PAR_SHORT = 3;
  localparam int PAR_LONG  = 5;
endpackage

// File: rtl/hrf_hdr_buf.sv
module hrf_hdr_buf
  import hrf_pkg::*;
#(
  parameter int HDR_WORDS = HDR_WDS,
  parameter int N_MOVES   = MOVES,
  parameter int IW        = IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [$clog2(HDR_WORDS)-1:0] wr_idx,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         start,
  input  logic [N_MOVES*IW-1:0]        cfg,
  output logic                         busy,
  output logic [HDR_WORDS*WORD_W-1:0]  hdr_flat
);
  localparam int NB   = HDR_WORDS * WORD_B;
  localparam int PB_W = $clog2(NB);
  localparam int ST_W = $clog2(N_MOVES + 1);

  logic [BYTE_W-1:0]       hb [NB];
  logic [ST_W-1:0]         step;
  logic                    busy_q;
  logic [N_MOVES*IW-1:0]   cfg_q;
  logic [IW-1:0]           cur_idx;
  logic [PB_W-1:0]         pos_a, pos_b;

  assign cur_idx = cfg_q[int'(step)*IW +: IW];
  assign pos_a   = PB_W'(step);
  assign pos_b   = PB_W'(cur_idx);
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step   <= '0;
      cfg_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      step   <= '0;
      cfg_q  <= cfg;
    end else if (busy_q) begin
      if (step == ST_W'(N_MOVES - 1)) busy_q <= 1'b0;
      step <= step + 1'b1;
    end
  end

  // capture and swap share one writer so each byte has a single driver
  always_ff @(posedge clk) begin
    for (int p = 0; p < NB; p++) begin
      if (wr_en && (int'(wr_idx) == p / WORD_B))
        hb[p] <= wr_data[WORD_W-1-BYTE_W*(p%WORD_B) -: BYTE_W];
      else if (busy_q && (PB_W'(p) == pos_a))
        hb[p] <= hb[pos_b];
      else if (busy_q && (PB_W'(p) == pos_b))
        hb[p] <= hb[pos_a];
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign hdr_flat[NB*BYTE_W-1-BYTE_W*g -: BYTE_W] = hb[g];
  end

  a_r4_step_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step < ST_W'(N_MOVES)));
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> $stable(cfg_q));
endmodule

// File: rtl/hrf_pay_buf.sv
module hrf_pay_buf
  import hrf_pkg::*;
#(
  parameter int PAY_WORDS = CELL_WDS - HDR_WDS
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(PAY_WORDS)-1:0] wr_idx,
  input  logic [WORD_W-1:0]            wr_data,
  output logic [PAY_WORDS*WORD_W-1:0]  pay_flat
);
  localparam int PW_W = $clog2(PAY_WORDS);

  for (genvar w = 0; w < PAY_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] mem_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PW_W'(w))) mem_q <= wr_data;
    end
    assign pay_flat[PAY_WORDS*WORD_W-1-WORD_W*w -: WORD_W] = mem_q;
  end
endmodule

// File: rtl/hrf_parity.sv
module hrf_parity
  import hrf_pkg::*;
#(
  parameter int N_LONG  = PAR_LONG,
  parameter int N_SHORT = PAR_SHORT
) (
  input  logic [N_LONG*BYTE_W-1:0] hdr_bytes,
  input  logic                     sel_long,
  output logic                     odd
);
  logic odd_short, odd_long;
  assign odd_short = ^hdr_bytes[N_LONG*BYTE_W-1 -: N_SHORT*BYTE_W];
  assign odd_long  = ^hdr_bytes;
  assign odd       = sel_long ? odd_long : odd_short;
endmodule

// File: rtl/hrf_out_seq.sv
module hrf_out_seq #(
  parameter int NUM_LU = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cell_done,
  input  logic                      hold_off,
  input  logic                      out_ready,
  output logic                      full,
  output logic                      out_valid,
  output logic [$clog2(NUM_LU)-1:0] lu
);
  localparam int LU_W = $clog2(NUM_LU);
  localparam logic [LU_W-1:0] LAST = LU_W'(NUM_LU - 1);

  logic fire;
  assign out_valid = full && !hold_off;
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      lu   <= '0;
    end else begin
      if (cell_done) full <= 1'b1;
      else if (fire && (lu == LAST)) full <= 1'b0;
      if (fire) lu <= (lu == LAST) ? '0 : lu + 1'b1;
    end
  end

  a_r3_lu_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (lu != LAST)) |=> (out_valid && (lu == $past(lu) + 1'b1)));
  a_r3_first_beat_lu0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> (lu == '0));
endmodule

// File: rtl/hrf_formatter.sv
module hrf_formatter
  import hrf_pkg::*;
#(
  parameter int CELL_WORDS = CELL_WDS,
  parameter int HDR_WORDS  = HDR_WDS,
  parameter int N_MOVES    = MOVES,
  parameter int IW         = IDX_W,
  parameter int LU_WORDS   = LU_WDS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MOVES*IW-1:0]       cfg_pos,
  input  logic                        cfg_par5,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [WORD_W-1:0]           in_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [LU_WORDS*WORD_W-1:0]  out_data,
  output logic                        out_sop,
  output logic [$clog2(CELL_WORDS/LU_WORDS)-1:0] out_lu,
  output logic                        out_par_err
);
  localparam int CNT_W     = $clog2(CELL_WORDS);
  localparam int HI_W      = $clog2(HDR_WORDS);
  localparam int PAY_WORDS = CELL_WORDS - HDR_WORDS;
  localparam int PI_W      = $clog2(PAY_WORDS);
  localparam int NUM_LU    = CELL_WORDS / LU_WORDS;
  localparam int LU_BITS   = LU_WORDS * WORD_W;
  localparam int CELL_BITS = CELL_WORDS * WORD_W;
  localparam int HDR_BITS  = HDR_WORDS * WORD_W;

  logic [CNT_W-1:0]     wcnt;
  logic                 take, start, cell_done, full, busy, par_sel_q, odd;
  logic [HDR_BITS-1:0]  hdr_flat;
  logic [PAY_WORDS*WORD_W-1:0] pay_flat;
  logic [CELL_BITS-1:0] cell_flat;

  assign in_ready  = !full;
  assign take      = in_valid && in_ready;
  assign start     = take && (wcnt == CNT_W'(HDR_WORDS - 1));
  assign cell_done = take && (wcnt == CNT_W'(CELL_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt      <= '0;
      par_sel_q <= 1'b0;
    end else begin
      if (take) wcnt <= cell_done ? '0 : wcnt + 1'b1;
      if (start) par_sel_q <= cfg_par5;
    end
  end

  hrf_hdr_buf #(.HDR_WORDS(HDR_WORDS), .N_MOVES(N_MOVES), .IW(IW)) u_hdr (
    .clk(clk), .rst_n(rst_n),
    .wr_en(take && (wcnt < CNT_W'(HDR_WORDS))),
    .wr_idx(HI_W'(wcnt)), .wr_data(in_data),
    .start(start), .cfg(cfg_pos), .busy(busy), .hdr_flat(hdr_flat)
  );

  hrf_pay_buf #(.PAY_WORDS(PAY_WORDS)) u_pay (
    .clk(clk),
    .wr_en(take && (wcnt >= CNT_W'(HDR_WORDS))),
    .wr_idx(PI_W'(wcnt - CNT_W'(HDR_WORDS))),
    .wr_data(in_data), .pay_flat(pay_flat)
  );

  hrf_parity #(.N_LONG(PAR_LONG), .N_SHORT(PAR_SHORT)) u_par (
    .hdr_bytes(hdr_flat[HDR_BITS-1 -: PAR_LONG*BYTE_W]),
    .sel_long(par_sel_q), .odd(odd)
  );

  hrf_out_seq #(.NUM_LU(NUM_LU)) u_seq (
    .clk(clk), .rst_n(rst_n), .cell_done(cell_done), .hold_off(busy),
    .out_ready(out_ready), .full(full), .out_valid(out_valid), .lu(out_lu)
  );

  assign cell_flat   = {hdr_flat, pay_flat};
  assign out_data    = cell_flat[CELL_BITS-1-int'(out_lu)*LU_BITS -: LU_BITS];
  assign out_sop     = out_valid && (out_lu == '0);
  assign out_par_err = out_sop && odd;

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lu)
                                   && $stable(out_par_err)));
  a_r2_ready_low_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (wcnt == CNT_W'(CELL_WORDS - 1))) |=> !in_ready);
  a_r4_moves_before_output: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !busy);
endmodule

// File: tb/tb_hrf_formatter.sv
`timescale 1ns/1ps
module tb_hrf_formatter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [14:0]  cfg_pos;
  logic         cfg_par5;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_data;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic         out_sop;
  logic [1:0]   out_lu;
  logic         out_par_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] words [16];
  logic [7:0]  e [64];
  logic        exp_err;

  always #10 clk = ~clk;

  hrf_formatter dut (
    .clk(clk), .rst_n(rst_n), .cfg_pos(cfg_pos), .cfg_par5(cfg_par5),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_lu(out_lu), .out_par_err(out_par_err)
  );

  task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [14:0] mk_cfg(int i0, int i1, int i2, int i3, int i4);
    return {3'(i4), 3'(i3), 3'(i2), 3'(i1), 3'(i0)};
  endfunction

  task automatic build_exp(logic [14:0] c, logic p5);
    for (int p = 0; p < 64; p++) e[p] = 8'(words[p/4] >> (24 - 8*(p%4)));
    for (int k = 0; k < 5; k++) begin
      int idx;
      logic [7:0] t;
      idx = int'(c[3*k +: 3]);
      t = e[k]; e[k] = e[idx]; e[idx] = t;
    end
    exp_err = p5 ? ^{e[0], e[1], e[2], e[3], e[4]} : ^{e[0], e[1], e[2]};
  endtask

  function automatic logic [127:0] exp_lu(int j);
    logic [127:0] r = '0;
    for (int n = 0; n < 16; n++) r = {r[119:0], e[16*j+n]};
    return r;
  endfunction

  task automatic fill_words(logic [31:0] base, logic [31:0] stepv);
    for (int w = 0; w < 16; w++) words[w] = base + stepv * 32'(w);
  endtask

  // gap: idle cycles before every word; change: swap config after word 4 taken
  task automatic send_cell(int gap, bit change, logic [14:0] c_alt);
    for (int w = 0; w < 16; w++) begin
      repeat (gap) begin
        @(negedge clk); in_valid = 1'b0; in_data = 32'hDEADBEEF;
      end
      @(negedge clk);
      if (change && w == 5) begin cfg_pos = c_alt; cfg_par5 = ~cfg_par5; end
      in_valid = 1'b1; in_data = words[w];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_data = 32'hDEADBEEF;
    check(in_ready == 1'b0, "R2", "in_ready after word 15", 128'(in_ready), 128'(0));
  endtask

  task automatic collect(bit stall, string tag);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (stall) begin
        logic [127:0] snap;
        out_ready = 1'b0;
        snap = out_data;
        @(negedge clk);
        check(out_valid && out_data == snap && out_lu == 2'(j), "R7",
              "held unit", out_data, snap);
        check(in_ready == 1'b0, "R2", "in_ready while held", 128'(in_ready), 128'(0));
      end
      out_ready = 1'b1;
      check(out_valid == 1'b1, "R3", "out_valid", 128'(out_valid), 128'(1));
      check(out_lu == 2'(j), "R3", "out_lu", 128'(out_lu), 128'(j));
      check(out_sop == (j == 0), "R3", "out_sop", 128'(out_sop), 128'(j == 0));
      check(out_data == exp_lu(j), tag, $sformatf("unit %0d data", j), out_data, exp_lu(j));
      check(out_par_err == ((j == 0) && exp_err), "R6", "parity flag",
            128'(out_par_err), 128'((j == 0) && exp_err));
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R3", "no fifth unit", 128'(out_valid), 128'(0));
    check(in_ready == 1'b1, "R2", "in_ready after unit 3", 128'(in_ready), 128'(1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready at reset", 128'(in_ready), 128'(1));
    check(out_valid == 1'b0, "R1", "out_valid at reset", 128'(out_valid), 128'(0));
  endtask

  task automatic t_identity();
    fill_words(32'hA0B1C2D3, 32'h01030507);
    cfg_pos = mk_cfg(0, 1, 2, 3, 4); cfg_par5 = 1'b0;
    build_exp(cfg_pos, cfg_par5);
    send_cell(0, 1'b0, '0);
    collect(1'b0, "R5");
  endtask

  task automatic t_chain();
    fill_words(32'h11223344, 32'h10203041);
    cfg_pos = mk_cfg(5, 0, 7, 1, 2); cfg_par5 = 1'b1;
    build_exp(cfg_pos, cfg_par5);
    send_cell(2, 1'b0, '0);
    collect(1'b0, "R4");
  endtask

  task automatic t_payload();
    fill_words(32'h0F1E2D3C, 32'h01010101);
    cfg_pos = mk_cfg(7, 6, 5, 4, 7); cfg_par5 = 1'b0;
    build_exp(cfg_pos, cfg_par5);
    send_cell(1, 1'b0, '0);
    collect(1'b0, "R9");
  endtask

  task automatic t_parity();
    fill_words(32'h55555555, 32'h0);
    words[0] = 32'h010000FF; words[1] = 32'h01000000;
    cfg_pos = mk_cfg(0, 1, 2, 3, 4); cfg_par5 = 1'b0;
    build_exp(cfg_pos, cfg_par5);
    send_cell(0, 1'b0, '0);
    collect(1'b0, "R6");
    cfg_par5 = 1'b1;
    build_exp(cfg_pos, cfg_par5);
    send_cell(0, 1'b0, '0);
    collect(1'b0, "R6");
  endtask

  task automatic t_stall();
    fill_words(32'h9ABC0123, 32'h0F0E0D0C);
    cfg_pos = mk_cfg(3, 6, 0, 5, 1); cfg_par5 = 1'b1;
    build_exp(cfg_pos, cfg_par5);
    send_cell(0, 1'b0, '0);
    collect(1'b1, "R7");
  endtask

  task automatic t_cfg_late();
    fill_words(32'h13579BDF, 32'h02468ACE);
    cfg_pos = mk_cfg(4, 7, 1, 0, 6); cfg_par5 = 1'b0;
    build_exp(cfg_pos, cfg_par5);
    send_cell(0, 1'b1, mk_cfg(2, 2, 2, 2, 2));
    collect(1'b0, "R8");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    cfg_pos = mk_cfg(0, 1, 2, 3, 4); cfg_par5 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_identity();
    t_chain();
    t_payload();
    t_parity();
    t_stall();
    t_cfg_late();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule